// File: doc/BRIEF.md
# Dual-clock shift/load register

A small register, four bits wide by default, that either shifts right one place or takes a parallel word. Each of these two operations has its own slow clock input, and a mode input picks which of the two is listened to. The block does not use those slow clocks as real clocks. It samples them, together with the mode input and the data inputs, on a fast system clock. From the sampled mode and clock levels it forms one selected clock. A high-to-low transition of that selected clock triggers one transfer.

In shift mode, a falling edge moves the serial bit into the lowest stage and every stage into the next higher one. In load mode, a falling edge copies the parallel word across. A left shift needs no extra logic: route each output to the parallel input one position below it and clock in load mode. The top output bit can drive the serial input of a further stage, so several registers can be chained. Mode changes follow fixed rules. A change that keeps the selected clock high, or low, leaves the contents alone. A change that drives the selected clock from high to low performs the transfer of the newly selected mode.

Top module: `dcsr_top`

## Requirements
- R1: While `rst_n` is low, `q_out` is all zeros, both after power-up and when reset is applied again during operation.
- R2: With `sel_load` = 1, a high-to-low transition of `load_clk` sets `q_out[i]` to `par_in[i]` for every bit i.
- R3: With `sel_load` = 0, a high-to-low transition of `shift_clk` sets `q_out[0]` to `ser_in` and `q_out[i]` to the old `q_out[i-1]` for i ≥ 1.
- R4: Transitions of the clock input that the mode does not select leave `q_out` unchanged. This is `shift_clk` when `sel_load` = 1 and `load_clk` when `sel_load` = 0.
- R5: A low-to-high transition of the selected clock leaves `q_out` unchanged.
- R6: Raising `sel_load` while `load_clk` is high leaves `q_out` unchanged.
- R7: Lowering `sel_load` while `shift_clk` is high and `load_clk` is low leaves `q_out` unchanged.
- R8: A change of `sel_load` that takes the selected clock from high to low performs one transfer in the mode selected after the change. Raising `sel_load` with `shift_clk` high and `load_clk` low loads `par_in`. Lowering `sel_load` with `load_clk` high and `shift_clk` low shifts in `ser_in`.
- R9: Each falling edge of the selected clock gives exactly one transfer. `q_out` takes its new value on the third rising edge of `clk` after the edge appears at the ports, and not earlier.
- R10: With `par_in[i]` wired to `q_out[i+1]` for i below the top bit and `sel_load` = 1, each `load_clk` falling edge shifts the contents one place toward bit 0. The top bit takes the value of `par_in[WIDTH-1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock; all sampling and state changes on its rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, to be released in step with `clk` |
| sel_load | input | 1 | Mode select: 1 selects `load_clk` and parallel load, 0 selects `shift_clk` and right shift |
| shift_clk | input | 1 | Slow clock for the shift operation, acts on its falling edge |
| load_clk | input | 1 | Slow clock for the load operation, acts on its falling edge |
| ser_in | input | 1 | Serial bit entering the lowest stage on a shift |
| par_in | input | WIDTH | Parallel word taken on a load |
| q_out | output | WIDTH | Register contents; the top bit serves as the chaining output |

## Verification
All five kinds of input pass through a synchronizer of the same depth, two flops by default. An edge-detect register follows, then the output register. A change at the ports therefore reaches `q_out` on the third rising `clk` edge. The latency test drives a falling edge between clock edges and samples on falling `clk` edges. It shows `q_out` still unchanged after two rising edges and updated after the third. Every other stimulus holds each input level for at least four system cycles, and the bench samples only after that settling window. The ignore cases are read from `q_out` before the next stimulus.

// File: rtl/dcsr_pkg.sv
package dcsr_pkg;
  typedef enum logic {
    MODE_SHIFT = 1'b0,
    MODE_LOAD  = 1'b1
  } mode_e;
endpackage

// File: rtl/dcsr_sync.sv
module dcsr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_r, stg_nxt;

  generate
    if (STAGES == 1) begin : g_one
      always_comb stg_nxt = d;
    end else begin : g_many
      always_comb stg_nxt = {stg_r[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_r <= '0;
    else        stg_r <= stg_nxt;
  end

  assign q = stg_r[STAGES-1];
endmodule

// File: rtl/dcsr_clk_sel.sv
module dcsr_clk_sel
  import dcsr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_e mode_s,
  input  logic  sclk_s,
  input  logic  lclk_s,
  output logic  xfer
);
  logic eff_now;
  logic eff_prev_r;

  always_comb eff_now = (mode_s == MODE_LOAD) ? lclk_s : sclk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eff_prev_r <= 1'b0;
    else        eff_prev_r <= eff_now;
  end

  assign xfer = eff_prev_r & ~eff_now;
endmodule

// File: rtl/dcsr_core.sv
module dcsr_core
  import dcsr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer,
  input  mode_e            mode_s,
  input  logic             ser_s,
  input  logic [WIDTH-1:0] par_s,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_r, q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (xfer) begin
      if (mode_s == MODE_LOAD) q_nxt = par_s;
      else                     q_nxt = {q_r[WIDTH-2:0], ser_s};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q = q_r;
endmodule

// File: rtl/dcsr_top.sv
module dcsr_top
  import dcsr_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_load,
  input  logic             shift_clk,
  input  logic             load_clk,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] q_out
);
  localparam int SW       = WIDTH + 4;
  localparam int B_SER    = WIDTH;
  localparam int B_LCLK   = WIDTH + 1;
  localparam int B_SCLK   = WIDTH + 2;
  localparam int B_MODE   = WIDTH + 3;

  logic [SW-1:0]    raw_bus, sync_bus;
  mode_e            mode_s;
  logic             ser_s;
  logic [WIDTH-1:0] par_s;
  logic             xfer;

  assign raw_bus = {sel_load, shift_clk, load_clk, ser_in, par_in};

  dcsr_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_bus),
    .q     (sync_bus)
  );

  assign mode_s = mode_e'(sync_bus[B_MODE]);
  assign ser_s  = sync_bus[B_SER];
  assign par_s  = sync_bus[WIDTH-1:0];

  dcsr_clk_sel u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_s (mode_s),
    .sclk_s (sync_bus[B_SCLK]),
    .lclk_s (sync_bus[B_LCLK]),
    .xfer   (xfer)
  );

  dcsr_core #(.WIDTH(WIDTH)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .xfer   (xfer),
    .mode_s (mode_s),
    .ser_s  (ser_s),
    .par_s  (par_s),
    .q      (q_out)
  );
endmodule

// File: rtl/dcsr_chk.sv
module dcsr_chk
  import dcsr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xfer,
  input mode_e            mode_s,
  input logic             ser_s,
  input logic [WIDTH-1:0] par_s,
  input logic [WIDTH-1:0] q
);
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && mode_s == MODE_LOAD) |=> (q == $past(par_s)));

  assert_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && mode_s == MODE_SHIFT) |=> (q == {$past(q[WIDTH-2:0]), $past(ser_s)}));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(q));

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> !xfer);
endmodule

bind dcsr_top dcsr_chk #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .xfer   (xfer),
  .mode_s (mode_s),
  .ser_s  (ser_s),
  .par_s  (par_s),
  .q      (q_out)
);

// File: tb/tb_dcsr_top.sv
`timescale 1ns/1ps
module tb_dcsr_top;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         sel_load, shift_clk, load_clk, ser_in;
  logic [W-1:0] par_in;
  logic [W-1:0] q_out;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  dcsr_top #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .sel_load(sel_load), .shift_clk(shift_clk),
    .load_clk(load_clk), .ser_in(ser_in), .par_in(par_in), .q_out(q_out)
  );

  // vector: [9] mode, [8] serial bit, [7:4] parallel word, [3:0] expected q
  localparam logic [9:0] VEC [8] = '{
    {1'b0, 1'b1, 4'b0000, 4'b0001},
    {1'b0, 1'b0, 4'b1111, 4'b0010},
    {1'b0, 1'b1, 4'b0000, 4'b0101},
    {1'b1, 1'b0, 4'b1010, 4'b1010},
    {1'b0, 1'b1, 4'b0000, 4'b0101},
    {1'b1, 1'b1, 4'b0111, 4'b0111},
    {1'b0, 1'b0, 4'b1001, 4'b1110},
    {1'b1, 1'b1, 4'b0000, 4'b0000}
  };

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic pulse(input bit use_load);
    if (use_load) load_clk = 1'b1; else shift_clk = 1'b1;
    wait_cyc(4);
    if (use_load) load_clk = 1'b0; else shift_clk = 1'b0;
    wait_cyc(4);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wait_cyc(3);
    chk("R1 reset", q_out, '0);
    rst_n = 1'b1;
    wait_cyc(3);
  endtask

  initial begin
    logic [W-1:0] exp_q;
    rst_n = 1'b0; sel_load = 1'b0; shift_clk = 1'b0; load_clk = 1'b0;
    ser_in = 1'b0; par_in = '0;
    wait_cyc(1);
    do_reset();

    // table walk (R2 loads, R3 shifts)
    for (int i = 0; i < 8; i++) begin
      sel_load = VEC[i][9];
      ser_in   = VEC[i][8];
      par_in   = VEC[i][7:4];
      wait_cyc(4);
      pulse(VEC[i][9]);
      chk(VEC[i][9] ? "R2 load vector" : "R3 shift vector", q_out, VEC[i][3:0]);
    end

    // R4: unselected clocks do nothing
    sel_load = 1'b1; par_in = 4'b0110; wait_cyc(4); pulse(1'b1);
    chk("R2 load 0110", q_out, 4'b0110);
    ser_in = 1'b1; pulse(1'b0);
    chk("R4 shift clock ignored in load mode", q_out, 4'b0110);
    sel_load = 1'b0; par_in = 4'b1001; wait_cyc(4); pulse(1'b1);
    chk("R4 load clock ignored in shift mode", q_out, 4'b0110);

    // R5: rising edge of selected clock does nothing
    shift_clk = 1'b1; wait_cyc(5);
    chk("R5 rising edge no change", q_out, 4'b0110);
    shift_clk = 1'b0; wait_cyc(5);
    chk("R3 shift after hold", q_out, 4'b1101);

    // R6: raise mode with load clock high
    par_in = 4'b1111; load_clk = 1'b1; wait_cyc(4);
    sel_load = 1'b1; wait_cyc(5);
    chk("R6 mode rise with load clock high", q_out, 4'b1101);
    load_clk = 1'b0; wait_cyc(5);
    chk("R2 load after mode rise", q_out, 4'b1111);

    // R7: lower mode with shift clock high, load clock low
    ser_in = 1'b0; shift_clk = 1'b1; wait_cyc(4);
    sel_load = 1'b0; wait_cyc(5);
    chk("R7 mode fall with shift clock high", q_out, 4'b1111);
    shift_clk = 1'b0; wait_cyc(5);
    chk("R3 shift after mode fall", q_out, 4'b1110);

    // R8: mode change causing a falling selected clock
    par_in = 4'b0011; shift_clk = 1'b1; wait_cyc(4);
    sel_load = 1'b1; wait_cyc(5);
    chk("R8 mode rise forces load", q_out, 4'b0011);
    shift_clk = 1'b0; ser_in = 1'b1; load_clk = 1'b1; wait_cyc(4);
    sel_load = 1'b0; wait_cyc(5);
    chk("R8 mode fall forces shift", q_out, 4'b0111);
    load_clk = 1'b0; wait_cyc(4);
    chk("R4 load clock fall ignored after mode fall", q_out, 4'b0111);

    // R9: latency of exactly three rising edges
    ser_in = 1'b0; shift_clk = 1'b1; wait_cyc(5);
    shift_clk = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R9 not before third edge", q_out, 4'b0111);
    @(posedge clk); @(negedge clk);
    chk("R9 on third edge", q_out, 4'b1110);
    wait_cyc(4);
    chk("R9 single transfer", q_out, 4'b1110);

    // R10: left shift via external wiring
    sel_load = 1'b1; par_in = 4'b1011; wait_cyc(4); pulse(1'b1);
    chk("R2 load 1011", q_out, 4'b1011);
    exp_q = 4'b1011;
    for (int k = 0; k < 3; k++) begin
      logic top_bit;
      top_bit = k[0];
      par_in = {top_bit, q_out[W-1:1]};
      wait_cyc(4);
      pulse(1'b1);
      exp_q = {top_bit, exp_q[W-1:1]};
      chk("R10 left shift by wiring", q_out, exp_q);
    end

    // R1: reset during operation
    do_reset();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule